// File: doc/BRIEF.md
# Jittered Fixed-Frequency PWM Oscillator

This block is the switching timebase of a current-mode flyback controller. A phase counter, clocked by the system clock, sets the length of each switching cycle. That length comes from a nominal period, chosen by a two-bit select input, plus a signed offset. A slow, stepped triangle supplies the offset. Over each sweep the switching frequency moves evenly above and below its nominal value by about four percent, which spreads the conducted emission spectrum.

Each cycle opens with a one-clock start strobe. The gate-enable output rises in that same clock. The gate falls at the first of two events. One is the clock after an external current-limit flag is sampled outside the leading-edge blanking window. The other is the end of the duty window, which is three quarters of the present cycle. Once low, the gate stays low until the next cycle starts. An enable input stops all switching at once and holds the phase counter at zero. The comparators, the gate driver and the slope compensation sit outside this block.

Top module: `jit_pwm_osc`

## Requirements
- R1: `fsel_i` selects the nominal period in clocks, round(CLK_HZ / f). Code 0 selects 65 kHz, code 1 selects 100 kHz, code 2 selects 130 kHz, and code 3 behaves as code 0. At the default 20 MHz clock these periods are 308, 200 and 154 clocks.
- R2: The period of a cycle is base + (L * D) / Q, using signed division that truncates toward zero. Here D = round(base * 4 / 100) and Q = QSTEPS (default 4). L is the triangle level of the sweep step s. A step counter advances once every SWEEP_CLKS / (4Q) clocks and wraps after 4Q steps, where SWEEP_CLKS = CLK_HZ * SWEEP_US / 1e6. The level is L = s for s <= Q, L = 2Q - s for s <= 3Q, and L = s - 4Q otherwise.
- R3: The period and the duty limit of a cycle are fixed from the step value present in the cycle's start clock. A step change later in the cycle does not alter that cycle's length.
- R4: `cycle_start_o` is high for exactly one clock, phase 0, of every cycle, and `gate_o` is high in that clock.
- R5: With no current-limit flag, `gate_o` is high during phases 0 to floor(3P/4) - 1 of a cycle of P clocks and low for the rest of the cycle.
- R6: `ilim_i` is ignored during phases 0 to LEB - 1, where LEB = round(LEB_NS * CLK_HZ / 1e9), which is 5 clocks by default. A flag held high from phase 0 therefore yields an on-time of LEB + 1 clocks.
- R7: If `ilim_i` is high at the clock edge that ends phase p, with p >= LEB, then `gate_o` is low from phase p + 1 until the next cycle start. Each new cycle re-arms the gate.
- R8: While `en_i` is low, `gate_o` and `cycle_start_o` are low in the same clock and the phase is held at 0. In the first clock with `en_i` high, a cycle starts.
- R9: While `rst_n` is low, both outputs are low. Reset restarts the sweep at step 0, so the first cycle after reset has the unmodulated base period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Run enable; low stops switching at once |
| fsel_i | input | 2 | Nominal frequency select (0: 65 kHz, 1: 100 kHz, 2: 130 kHz, 3: as 0) |
| ilim_i | input | 1 | Current-limit comparator flag |
| gate_o | output | 1 | Gate enable for the driver |
| cycle_start_o | output | 1 | One-clock strobe at phase 0 of each cycle |

## Verification
The bench measures whole cycles at each frequency code, including the code that falls back to code 0. It compares every cycle length with the level that the sweep held in the cycle's start clock. A design that sampled the offset mid-cycle, or that rounded the offset the wrong way, would produce cycle lengths a few clocks off. Current-limit flags are placed before, on and after the end of blanking, and past the duty limit. An off-by-one in the kill path or in the blanking window would shift the on-time by one clock, and a missing duty cap would let the gate run to the flag. The bench also drops enable in the middle of an on-time, expecting the gate low in that same clock and a fresh start on re-enable. After reset it expects the unmodulated base period.

// File: rtl/jit_pwm_pkg.sv
// Package: shared encodings and elaboration-time helpers for the jittered
// PWM oscillator. Assumes every argument is positive.
package jit_pwm_pkg;

    // Nominal frequency select codes; code 3 falls back to the low rate.
    typedef enum logic [1:0] {
        FSEL_LOW  = 2'd0,
        FSEL_MID  = 2'd1,
        FSEL_HIGH = 2'd2,
        FSEL_ALT  = 2'd3
    } fsel_e;

    // Integer division rounded to nearest.
    function automatic int div_round(longint num, longint den);
        return int'((num + den / 2) / den);
    endfunction

    // Larger of two integers.
    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/jit_sweep.sv
// Module: jit_sweep
// Produces the stepped triangle level that modulates the switching period.
// A sub-counter divides the clock down to one step per STEP_CLKS clocks.
// The step index wraps after 4*QSTEPS steps and maps to a signed level in
// -QSTEPS..+QSTEPS. Assumes QSTEPS >= 1. The sweep runs freely and only
// reset restarts it.
module jit_sweep #(
    parameter int CLK_HZ   = 20_000_000,
    parameter int SWEEP_US = 4000,
    parameter int QSTEPS   = 4,
    parameter int LVL_W    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic signed [LVL_W-1:0] level_o
);
    localparam longint SWEEP_CLKS = (longint'(CLK_HZ) / 1000) * longint'(SWEEP_US) / 1000;
    localparam int     NSTEPS     = 4 * QSTEPS;
    localparam int     STEP_CLKS  = (SWEEP_CLKS / NSTEPS < 1) ? 1 : int'(SWEEP_CLKS / NSTEPS);
    localparam int     SUB_W      = $clog2(STEP_CLKS + 1);
    localparam int     STEP_W     = $clog2(NSTEPS);
    localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(STEP_CLKS - 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NSTEPS - 1);

    logic [SUB_W-1:0]  sub_q;
    logic [STEP_W-1:0] step_q;

    // Clock divider and step index, both wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_q  <= '0;
            step_q <= '0;
        end else if (sub_q == SUB_LAST) begin
            sub_q  <= '0;
            step_q <= (step_q == STEP_LAST) ? '0 : step_q + 1'b1;
        end else begin
            sub_q <= sub_q + 1'b1;
        end
    end

    // Fold the step index into a symmetric triangle level.
    always_comb begin
        int s;
        int lvl;
        s = int'(step_q);
        if (s <= QSTEPS)          lvl = s;
        else if (s <= 3 * QSTEPS) lvl = 2 * QSTEPS - s;
        else                      lvl = s - NSTEPS;
        level_o = LVL_W'(lvl);
    end

endmodule

// File: rtl/jit_period_calc.sv
// Module: jit_period_calc
// Maps the frequency select and the sweep level to a cycle length in clocks
// and to the matching duty limit of floor(3P/4). The logic is purely
// combinational. Assumes PER_W holds the largest modulated period.
module jit_period_calc
    import jit_pwm_pkg::*;
#(
    parameter int CLK_HZ     = 20_000_000,
    parameter int F0_HZ      = 65_000,
    parameter int F1_HZ      = 100_000,
    parameter int F2_HZ      = 130_000,
    parameter int SPREAD_PCT = 4,
    parameter int QSTEPS     = 4,
    parameter int LVL_W      = 4,
    parameter int PER_W      = 9
) (
    input  logic [1:0]              fsel_i,
    input  logic signed [LVL_W-1:0] level_i,
    output logic [PER_W-1:0]        per_o,
    output logic [PER_W-1:0]        maxon_o
);
    localparam int B0 = div_round(CLK_HZ, F0_HZ);
    localparam int B1 = div_round(CLK_HZ, F1_HZ);
    localparam int B2 = div_round(CLK_HZ, F2_HZ);
    localparam int D0 = div_round(B0 * SPREAD_PCT, 100);
    localparam int D1 = div_round(B1 * SPREAD_PCT, 100);
    localparam int D2 = div_round(B2 * SPREAD_PCT, 100);

    // Choose base and spread, apply the scaled level, derive the duty cap.
    always_comb begin
        int base;
        int dev;
        int off;
        int per;
        case (fsel_i)
            FSEL_MID:  begin base = B1; dev = D1; end
            FSEL_HIGH: begin base = B2; dev = D2; end
            default:   begin base = B0; dev = D0; end
        endcase
        off     = (int'(level_i) * dev) / QSTEPS;
        per     = base + off;
        per_o   = PER_W'(per);
        maxon_o = PER_W'((per * 3) / 4);
    end

endmodule

// File: rtl/jit_phase_gen.sv
// Module: jit_phase_gen
// Runs the per-cycle phase counter and shapes the gate enable. The start
// clock (phase 0) loads the period and duty limit. The gate is high at
// phase 0, and a current-limit flag outside blanking or the duty limit
// drops it. Assumes LEB_CLKS >= 1 and a period of at least 2 clocks.
module jit_phase_gen #(
    parameter int PER_W    = 9,
    parameter int LEB_CLKS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             ilim_i,
    input  logic [PER_W-1:0] per_next_i,
    input  logic [PER_W-1:0] maxon_next_i,
    output logic             gate_o,
    output logic             start_o
);
    localparam logic [PER_W-1:0] LEB_V = PER_W'(LEB_CLKS);

    logic [PER_W-1:0] ph_q;
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] maxon_q;
    logic             killed_q;
    logic             at_zero;
    logic             at_end;
    logic             live;

    // Decode of the phase position and the run condition.
    always_comb begin
        at_zero = (ph_q == '0);
        at_end  = (ph_q == per_q - PER_W'(1));
        live    = rst_n && en_i;
    end

    // Outputs: strobe at phase 0; gate until killed or past the duty cap.
    always_comb begin
        start_o = live && at_zero;
        gate_o  = live && (at_zero || (!killed_q && (ph_q < maxon_q)));
    end

    // Phase counter, per-cycle limits and the current-limit kill flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q     <= '0;
            per_q    <= '0;
            maxon_q  <= '0;
            killed_q <= 1'b0;
        end else if (!en_i) begin
            ph_q     <= '0;
            killed_q <= 1'b0;
        end else if (at_zero) begin
            ph_q     <= PER_W'(1);
            per_q    <= per_next_i;
            maxon_q  <= maxon_next_i;
            killed_q <= 1'b0;
        end else if (at_end) begin
            ph_q     <= '0;
            killed_q <= 1'b0;
        end else begin
            ph_q <= ph_q + PER_W'(1);
            if (ilim_i && (ph_q >= LEB_V)) begin
                killed_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/jit_pwm_osc.sv
// Module: jit_pwm_osc (top)
// Jittered fixed-frequency PWM oscillator: a triangle sweep feeds the
// period calculator, and the phase generator turns the chosen period into a
// start strobe and a blanked, duty-capped gate enable. Assumes synchronous
// active-low reset and a current-limit flag already synchronized to clk.
module jit_pwm_osc
    import jit_pwm_pkg::*;
#(
    parameter int CLK_HZ     = 20_000_000,
    parameter int F0_HZ      = 65_000,
    parameter int F1_HZ      = 100_000,
    parameter int F2_HZ      = 130_000,
    parameter int SPREAD_PCT = 4,
    parameter int SWEEP_US   = 4000,
    parameter int QSTEPS     = 4,
    parameter int LEB_NS     = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] fsel_i,
    input  logic       ilim_i,
    output logic       gate_o,
    output logic       cycle_start_o
);
    localparam int B0       = div_round(CLK_HZ, F0_HZ);
    localparam int B1       = div_round(CLK_HZ, F1_HZ);
    localparam int B2       = div_round(CLK_HZ, F2_HZ);
    localparam int P0       = B0 + div_round(B0 * SPREAD_PCT, 100);
    localparam int P1       = B1 + div_round(B1 * SPREAD_PCT, 100);
    localparam int P2       = B2 + div_round(B2 * SPREAD_PCT, 100);
    localparam int MAX_PER  = imax(P0, imax(P1, P2));
    localparam int PER_W    = $clog2(MAX_PER + 1);
    localparam int LVL_W    = $clog2(QSTEPS + 1) + 1;
    localparam int LEB_RAW  = div_round(longint'(LEB_NS) * longint'(CLK_HZ), 64'd1_000_000_000);
    localparam int LEB_CLKS = (LEB_RAW < 1) ? 1 : LEB_RAW;

    logic signed [LVL_W-1:0] level;
    logic [PER_W-1:0]        per_next;
    logic [PER_W-1:0]        maxon_next;

    jit_sweep #(
        .CLK_HZ  (CLK_HZ),
        .SWEEP_US(SWEEP_US),
        .QSTEPS  (QSTEPS),
        .LVL_W   (LVL_W)
    ) u_sweep (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_o(level)
    );

    jit_period_calc #(
        .CLK_HZ    (CLK_HZ),
        .F0_HZ     (F0_HZ),
        .F1_HZ     (F1_HZ),
        .F2_HZ     (F2_HZ),
        .SPREAD_PCT(SPREAD_PCT),
        .QSTEPS    (QSTEPS),
        .LVL_W     (LVL_W),
        .PER_W     (PER_W)
    ) u_calc (
        .fsel_i (fsel_i),
        .level_i(level),
        .per_o  (per_next),
        .maxon_o(maxon_next)
    );

    jit_phase_gen #(
        .PER_W   (PER_W),
        .LEB_CLKS(LEB_CLKS)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .ilim_i      (ilim_i),
        .per_next_i  (per_next),
        .maxon_next_i(maxon_next),
        .gate_o      (gate_o),
        .start_o     (cycle_start_o)
    );

endmodule

// File: rtl/jit_pwm_osc_chk.sv
// Module: jit_pwm_osc_chk
// Port-level checker bound to jit_pwm_osc. It rebuilds the phase from the
// start strobe and the enable, and checks strobe, blanking, kill and
// disable behaviour. Assumes the duty limit exceeds the blanking length.
module jit_pwm_osc_chk #(
    parameter int LEB_CLKS = 5
) (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic ilim_i,
    input logic gate_o,
    input logic cycle_start_o
);
    localparam logic [11:0] INVAL = '1;
    localparam logic [11:0] LEB_V = 12'(LEB_CLKS);

    logic [11:0] since_q;
    logic [11:0] ph_est;

    // Clocks since the last start; invalid after reset or a disable.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_q <= INVAL;
        else if (!en_i)             since_q <= INVAL;
        else if (cycle_start_o)     since_q <= 12'd1;
        else if (since_q != INVAL)  since_q <= since_q + 12'd1;
    end

    // Current phase estimate.
    always_comb ph_est = cycle_start_o ? 12'd0 : since_q;

    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |-> (!gate_o && !cycle_start_o));

    p_start_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_o |-> gate_o);

    p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_o |=> !cycle_start_o);

    p_disable_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (!gate_o && !cycle_start_o));

    p_blank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (ph_est != INVAL) && (ph_est < LEB_V)) |-> gate_o);

    p_ilim_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !cycle_start_o && $past(en_i) && $past(ilim_i)
         && ($past(ph_est) != INVAL) && ($past(ph_est) >= LEB_V)) |-> !gate_o);

    p_off_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !gate_o && !cycle_start_o) |=> (!gate_o || cycle_start_o));

endmodule

bind jit_pwm_osc jit_pwm_osc_chk #(.LEB_CLKS(LEB_CLKS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .ilim_i       (ilim_i),
    .gate_o       (gate_o),
    .cycle_start_o(cycle_start_o)
);

// File: tb/sim_jit_pwm_osc.sv
// Bench for jit_pwm_osc: a vector table of frequency code and flag phase,
// then directed reset, boundary and enable tests.
module sim_jit_pwm_osc;
    localparam int CLK_HZ   = 20_000_000;
    localparam int SWEEP_US = 40;
    localparam int Q        = 4;
    localparam int STEP     = ((CLK_HZ / 1000) * SWEEP_US / 1000) / (4 * Q);
    localparam int LEB      = 5;
    localparam int NV       = 12;
    // {fsel, flag phase (-1 = none)}
    localparam int VEC [0:NV-1][0:1] = '{
        '{0, -1}, '{1, -1}, '{2, -1}, '{3, -1},
        '{1, 0},  '{0, 1},  '{2, 4},  '{0, 5},
        '{1, 60}, '{2, 30}, '{0, 200}, '{2, 140}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en_i;
    logic [1:0] fsel_i;
    logic       ilim_i;
    logic       gate_o;
    logic       cycle_start_o;
    longint     kcnt;
    int         checks = 0;
    int         errors = 0;

    jit_pwm_osc #(.CLK_HZ(CLK_HZ), .SWEEP_US(SWEEP_US), .QSTEPS(Q)) u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .fsel_i(fsel_i),
        .ilim_i(ilim_i), .gate_o(gate_o), .cycle_start_o(cycle_start_o)
    );

    always #4 clk = ~clk;

    // Clock edges since reset release, the sweep's time base.
    always @(posedge clk) begin
        if (!rst_n) kcnt <= 0;
        else        kcnt <= kcnt + 1;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int base_of(input int fs);
        int f;
        f = (fs == 1) ? 100_000 : (fs == 2) ? 130_000 : 65_000;
        return (CLK_HZ + f / 2) / f;
    endfunction

    function automatic int exp_period(input int fs, input longint k0);
        int b, d, s, l;
        b = base_of(fs);
        d = (b * 4 + 50) / 100;
        s = int'((k0 / STEP) % (4 * Q));
        if (s <= Q)          l = s;
        else if (s <= 3 * Q) l = 2 * Q - s;
        else                 l = s - 4 * Q;
        return b + (l * d) / Q;
    endfunction

    function automatic int exp_on(input int p, input int ph);
        int cap, t;
        cap = (p * 3) / 4;
        if (ph < 0) return cap;
        t = ((ph > LEB) ? ph : LEB) + 1;
        return (t < cap) ? t : cap;
    endfunction

    task automatic wait_start();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cycle_start_o && n < 2000);
    endtask

    // Called at phase 0 of a cycle; measures its length and on-time.
    task automatic measure(input int fph, output int per, output int on,
                           output int g0, output longint k0);
        k0 = kcnt; per = 0; on = 0; g0 = int'(gate_o);
        while (1) begin
            if (per == fph) ilim_i = 1'b1;
            if (gate_o) on++;
            per++;
            @(negedge clk);
            if (cycle_start_o || per > 2000) break;
        end
        ilim_i = 1'b0;
    endtask

    initial begin
        #(8 * 190_000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int per, on, g0, ep, hi;
        longint k0;
        rst_n = 1'b0; en_i = 1'b1; fsel_i = 2'd0; ilim_i = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R9 gate in reset", int'(gate_o), 0);
        check("R9 start in reset", int'(cycle_start_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R8 start on first enabled clock", int'(cycle_start_o), 1);
        measure(-1, per, on, g0, k0);
        check("R9 base period after reset", per, 308);
        check("R5 duty cap after reset", on, 231);
        check("R4 gate at phase 0", g0, 1);
        check("R4 single-clock strobe", int'(cycle_start_o), 1);
        @(negedge clk);
        check("R4 strobe falls after phase 0", int'(cycle_start_o), 0);

        for (int v = 0; v < NV; v++) begin
            fsel_i = VEC[v][0][1:0];
            wait_start();
            measure(VEC[v][1], per, on, g0, k0);
            ep = exp_period(VEC[v][0], k0);
            check((VEC[v][0] == 3) ? "R1 code 3 period" : "R2 period", per, ep);
            if (VEC[v][1] < 0)
                check("R5 on-time", on, exp_on(ep, -1));
            else if (VEC[v][1] < LEB)
                check("R6 on-time", on, exp_on(ep, VEC[v][1]));
            else if (VEC[v][1] + 1 >= (ep * 3) / 4)
                check("R5 capped on-time", on, exp_on(ep, VEC[v][1]));
            else
                check("R7 on-time", on, exp_on(ep, VEC[v][1]));
        end

        // Back-to-back cycles that span step changes.
        fsel_i = 2'd2;
        wait_start();
        for (int c = 0; c < 6; c++) begin
            measure(-1, per, on, g0, k0);
            check("R3 period fixed at start", per, exp_period(2, k0));
        end

        // Enable drop in the middle of an on-time.
        fsel_i = 2'd1;
        wait_start();
        repeat (10) @(negedge clk);
        en_i = 1'b0;
        #1;
        check("R8 gate low same clock", int'(gate_o), 0);
        check("R8 start low while off", int'(cycle_start_o), 0);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (gate_o || cycle_start_o) hi++;
        end
        check("R8 quiet while disabled", hi, 0);
        en_i = 1'b1;
        #1;
        check("R8 restart on enable", int'(cycle_start_o), 1);
        measure(-1, per, on, g0, k0);
        ep = exp_period(1, k0);
        check("R8 period after enable", per, ep);
        check("R5 on-time after enable", on, (ep * 3) / 4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule